// File: doc/BRIEF.md
# Three-Bank Cartridge Mapper with Split-Port RAM

This block sits on an 8-bit CPU cartridge slot that exposes a 4 KB window. It watches a 13-bit CPU address, a write flag and an access strobe. Bit 12 of the address selects the cartridge. Only the low 12 bits, the offset, are decoded inside the window. A 2-bit bank register picks one of three 4 KB banks in a 12 KB external ROM. The mapper drives the 14-bit ROM address and returns the ROM byte on cartridge reads.

Three fixed offsets near the top of the window act as bank-select triggers. Any qualified access to one of them, read or write, changes the bank. The block also holds a 256-byte RAM that is reached through two address ranges. Writes go to one range. Reads come from the other range, and also from the write range.

Top module: `tribank_mapper`

## Requirements
- R1: An access with cpuAddr[12] low is ignored. It does not change the bank or the RAM, rdDrive stays 0 and rdData reads 0.
- R2: After reset the bank register holds 2. The first ROM read at offset X then presents romAddr = 0x2000 + X.
- R3: A qualified access to offset 0xFF8, 0xFF9 or 0xFFA selects bank 0, 1 or 2 respectively, whether it is a read or a write. Later ROM reads use romAddr = bank*4096 + offset. Offset 0xFFB selects nothing.
- R4: A read that hits a bank-select offset returns the ROM byte of the newly selected bank in that same access (romAddr = newBank*4096 + offset).
- R5: A qualified write to offsets 0x000–0x0FF stores wrData at RAM index offset[7:0]. A read at offset 0x100 + index returns that byte.
- R6: A write to offsets 0x100–0x1FF leaves the RAM contents unchanged.
- R7: A write to a bank-select offset stores nothing in the RAM. In particular, RAM index 0xF8–0xFA keeps its value.
- R8: A read at offsets 0x200–0xFFF returns romData, with romAddr = currentBank*4096 + offset.
- R9: A read at offsets 0x000–0x0FF returns the stored RAM byte at offset[7:0] and leaves it unchanged.
- R10: With accessStrobe low, the bank and the RAM keep their values and rdDrive stays 0.
- R11: rdDrive is 1 only for a qualified cartridge read. Writes never drive read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 13 | CPU address; bit 12 selects the cartridge |
| cpuWrite | input | 1 | 1 = write access, 0 = read access |
| accessStrobe | input | 1 | Qualifies the access in this cycle |
| wrData | input | 8 | CPU write data |
| romData | input | 8 | Byte returned by the external ROM for romAddr |
| romAddr | output | 14 | Address to the external ROM |
| rdData | output | 8 | Read data for the CPU; 0 when not driven |
| rdDrive | output | 1 | 1 while the cartridge drives rdData |

## Verification
A bank switch and a ROM fetch can fall in the same cycle: a read at a bank-select offset both loads the bank register and must return data from the bank being selected. The bench reads each select offset and checks the romAddr and rdData presented during that same access against newBank*4096 + offset. It then reads an ordinary offset and confirms that the switch persisted. A write to a select offset whose low byte aliases a RAM index is also applied. That RAM index is then read back to confirm the bank change and the RAM store did not both occur.

// File: rtl/tribank_pkg.sv
package tribank_pkg;
  localparam int OFFSET_W  = 12;
  localparam int DATA_W    = 8;
  localparam int RAM_AW    = 8;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 3;
  localparam int ROM_AW    = BANK_W + OFFSET_W;
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int PAGE_W    = OFFSET_W - RAM_AW;

  typedef struct packed {
    logic              bankLoad;
    logic [BANK_W-1:0] bankSel;
    logic              ramWrite;
    logic              ramRead;
    logic              romRead;
    logic              driveOut;
  } ctrl_strobes_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import tribank_pkg::*;
#(
  parameter logic [OFFSET_W-1:0] HOT_BASE   = 12'hFF8,
  parameter logic [BANK_W-1:0]   RESET_BANK = 2'd2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cartSel,
  input  logic [OFFSET_W-1:0] offset,
  input  logic                isWrite,
  input  logic                strobe,
  output ctrl_strobes_t       strb,
  output logic [BANK_W-1:0]   curBank,
  output logic [BANK_W-1:0]   effBank
);
  logic              hit;
  logic [BANK_W-1:0] hitBank;
  logic              qualified;
  logic              inWritePort;
  logic              inReadPort;
  logic [BANK_W-1:0] bankReg;

  // Bank-select offset decode: HOT_BASE + b selects bank b
  always_comb begin
    hit     = 1'b0;
    hitBank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (offset == OFFSET_W'(int'(HOT_BASE) + b)) begin
        hit     = 1'b1;
        hitBank = BANK_W'(b);
      end
    end
  end

  assign qualified   = strobe & cartSel;
  assign inWritePort = (offset[OFFSET_W-1:RAM_AW] == '0);
  assign inReadPort  = (offset[OFFSET_W-1:RAM_AW] == PAGE_W'(1));

  always_comb begin
    strb.bankLoad = qualified & hit;
    strb.bankSel  = hitBank;
    strb.ramWrite = qualified & isWrite & inWritePort;
    strb.ramRead  = qualified & ~isWrite & (inWritePort | inReadPort);
    strb.romRead  = qualified & ~isWrite & ~(inWritePort | inReadPort);
    strb.driveOut = qualified & ~isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bankReg <= RESET_BANK;
    else if (strb.bankLoad) bankReg <= strb.bankSel;
  end

  assign curBank = bankReg;
  // A select read fetches from the bank it is selecting
  assign effBank = strb.bankLoad ? strb.bankSel : bankReg;
endmodule

// File: rtl/mapper_dpath.sv
module mapper_dpath
  import tribank_pkg::*;
(
  input  logic                clk,
  input  ctrl_strobes_t       strb,
  input  logic [OFFSET_W-1:0] offset,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [BANK_W-1:0]   effBank,
  input  logic [DATA_W-1:0]   romData,
  output logic [ROM_AW-1:0]   romAddr,
  output logic [DATA_W-1:0]   rdData
);
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (strb.ramWrite) mem[offset[RAM_AW-1:0]] <= wrData;
  end

  assign romAddr = {effBank, offset};

  always_comb begin
    if (strb.ramRead)      rdData = mem[offset[RAM_AW-1:0]];
    else if (strb.romRead) rdData = romData;
    else                   rdData = '0;
  end
endmodule

// File: rtl/tribank_mapper.sv
module tribank_mapper
  import tribank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFFSET_W:0]   cpuAddr,
  input  logic                cpuWrite,
  input  logic                accessStrobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   romData,
  output logic [ROM_AW-1:0]   romAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdDrive
);
  ctrl_strobes_t     strb;
  logic [BANK_W-1:0] curBank;
  logic [BANK_W-1:0] effBank;

  mapper_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cartSel (cpuAddr[OFFSET_W]),
    .offset  (cpuAddr[OFFSET_W-1:0]),
    .isWrite (cpuWrite),
    .strobe  (accessStrobe),
    .strb    (strb),
    .curBank (curBank),
    .effBank (effBank)
  );

  mapper_dpath u_dpath (
    .clk     (clk),
    .strb    (strb),
    .offset  (cpuAddr[OFFSET_W-1:0]),
    .wrData  (wrData),
    .effBank (effBank),
    .romData (romData),
    .romAddr (romAddr),
    .rdData  (rdData)
  );

  assign rdDrive = strb.driveOut;
endmodule

// File: rtl/tribank_mapper_chk.sv
module tribank_mapper_chk (
  input logic        clk,
  input logic        rstN,
  input logic [12:0] cpuAddr,
  input logic        cpuWrite,
  input logic        accessStrobe,
  input logic [13:0] romAddr,
  input logic [7:0]  rdData,
  input logic        rdDrive,
  input logic [1:0]  curBank
);
  // R1: outside the window nothing is driven
  p_ignore_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[12] |-> (!rdDrive && rdData == 8'h00));

  // R1: accesses outside the window leave the bank alone
  p_bank_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[12] |=> $stable(curBank));

  // R2: reset leaves bank 2
  p_reset_bank_r2: assert property (@(posedge clk)
    !rstN |=> curBank == 2'd2);

  // R3: select offsets FF8..FFA load bank = address bits [1:0]
  p_hot_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accessStrobe && cpuAddr[12] && cpuAddr[11:0] >= 12'hFF8 && cpuAddr[11:0] <= 12'hFFA)
      |=> curBank == $past(cpuAddr[1:0]));

  // R8: ordinary ROM reads address the held bank
  p_rom_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdDrive && cpuAddr[11:8] != 4'h0 && cpuAddr[11:8] != 4'h1
      && !(cpuAddr[11:0] >= 12'hFF8 && cpuAddr[11:0] <= 12'hFFA))
      |-> romAddr == {curBank, cpuAddr[11:0]});

  // R10: no strobe, no bank change and no drive
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accessStrobe |=> ($stable(curBank)));

  // R11: writes never drive read data
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrite || !accessStrobe) |-> !rdDrive);
endmodule

bind tribank_mapper tribank_mapper_chk u_chk (.*);

// File: tb/tribank_mapper_bench.sv
module tribank_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] cpuAddr = '0;
  logic        cpuWrite = 1'b0;
  logic        accessStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  romData;
  logic [13:0] romAddr;
  logic [7:0]  rdData;
  logic        rdDrive;

  int nChecks = 0;
  int nFail = 0;

  // ROM model: bank bits land in the low data bits so banks differ
  function automatic logic [7:0] romByte(input logic [13:0] a);
    return a[7:0] ^ {a[11:8], 2'b10, a[13:12]};
  endfunction

  assign romData = romByte(romAddr);

  always #(CLK_PERIOD/2) clk = ~clk;

  tribank_mapper u_tribank_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .accessStrobe(accessStrobe), .wrData(wrData), .romData(romData),
    .romAddr(romAddr), .rdData(rdData), .rdDrive(rdDrive)
  );

  // {wr, addr13, wdata8, chk2, expRomAddr14, expVal8, req4}
  // chk: 0 none, 1 ROM read, 2 RAM read literal, 3 not driven
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 13'h1200, 8'h00, 2'd1, 14'h2200, 8'h00, 4'd2},  // R2 reset bank
    {1'b1, 13'h1010, 8'h5A, 2'd3, 14'h0000, 8'h00, 4'd5},  // R5 store
    {1'b0, 13'h1110, 8'h00, 2'd2, 14'h0000, 8'h5A, 4'd5},  // R5 read port
    {1'b0, 13'h1010, 8'h00, 2'd2, 14'h0000, 8'h5A, 4'd9},  // R9 write port read
    {1'b0, 13'h1110, 8'h00, 2'd2, 14'h0000, 8'h5A, 4'd9},  // R9 unchanged
    {1'b1, 13'h1110, 8'h33, 2'd3, 14'h0000, 8'h00, 4'd6},  // R6 write read port
    {1'b0, 13'h1110, 8'h00, 2'd2, 14'h0000, 8'h5A, 4'd6},  // R6 unchanged
    {1'b1, 13'h10F9, 8'hC3, 2'd3, 14'h0000, 8'h00, 4'd5},  // R5 store F9
    {1'b0, 13'h1FF8, 8'h00, 2'd1, 14'h0FF8, 8'h00, 4'd4},  // R4 select read
    {1'b0, 13'h1345, 8'h00, 2'd1, 14'h0345, 8'h00, 4'd3},  // R3 bank 0 held
    {1'b1, 13'h1FF9, 8'h77, 2'd3, 14'h0000, 8'h00, 4'd7},  // R7 select write
    {1'b0, 13'h1ABC, 8'h00, 2'd1, 14'h1ABC, 8'h00, 4'd3},  // R3 bank 1
    {1'b0, 13'h11F9, 8'h00, 2'd2, 14'h0000, 8'hC3, 4'd7},  // R7 RAM kept
    {1'b0, 13'h0FF8, 8'h00, 2'd3, 14'h0000, 8'h00, 4'd1},  // R1 outside
    {1'b1, 13'h0010, 8'h99, 2'd3, 14'h0000, 8'h00, 4'd1},  // R1 outside write
    {1'b0, 13'h1110, 8'h00, 2'd2, 14'h0000, 8'h5A, 4'd1},  // R1 RAM kept
    {1'b0, 13'h1800, 8'h00, 2'd1, 14'h1800, 8'h00, 4'd1},  // R1 bank kept
    {1'b0, 13'h1FFB, 8'h00, 2'd1, 14'h1FFB, 8'h00, 4'd3},  // R3 FFB inert
    {1'b0, 13'h1FFA, 8'h00, 2'd1, 14'h2FFA, 8'h00, 4'd4},  // R4 to bank 2
    {1'b0, 13'h1FFF, 8'h00, 2'd1, 14'h2FFF, 8'h00, 4'd8},  // R8 top offset
    {1'b1, 13'h10FF, 8'hE1, 2'd3, 14'h0000, 8'h00, 4'd5},  // R5 top index
    {1'b0, 13'h11FF, 8'h00, 2'd2, 14'h0000, 8'hE1, 4'd5},  // R5
    {1'b1, 13'h1000, 8'h01, 2'd3, 14'h0000, 8'h00, 4'd5},  // R5 index 0
    {1'b0, 13'h1100, 8'h00, 2'd2, 14'h0000, 8'h01, 4'd5},  // R5
    {1'b1, 13'h10F8, 8'h5C, 2'd3, 14'h0000, 8'h00, 4'd11}, // R11 write quiet
    {1'b1, 13'h1FF8, 8'hAA, 2'd3, 14'h0000, 8'h00, 4'd7},  // R7 select write
    {1'b0, 13'h11F8, 8'h00, 2'd2, 14'h0000, 8'h5C, 4'd7},  // R7 F8 kept
    {1'b0, 13'h1200, 8'h00, 2'd1, 14'h0200, 8'h00, 4'd3},  // R3 write-selected
    {1'b0, 13'h1201, 8'h00, 2'd1, 14'h0201, 8'h00, 4'd8}   // R8 bank 0
  };

  task automatic check(input bit ok, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state: nothing driven
    check(rdDrive == 1'b0 && rdData == 8'h00, 2, {7'd0, rdDrive, rdData}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpuWrite     = VEC[i][49];
      cpuAddr      = VEC[i][48:36];
      wrData       = VEC[i][35:28];
      accessStrobe = 1'b1;
      #2;
      case (VEC[i][27:26])
        2'd1: begin
          check(romAddr == VEC[i][25:12], int'(VEC[i][3:0]),
                {2'b00, romAddr}, {2'b00, VEC[i][25:12]});
          check(rdDrive && rdData == romByte(VEC[i][25:12]), int'(VEC[i][3:0]),
                {7'd0, rdDrive, rdData}, {8'h01, romByte(VEC[i][25:12])});
        end
        2'd2: check(rdDrive && rdData == VEC[i][11:4], int'(VEC[i][3:0]),
                    {7'd0, rdDrive, rdData}, {8'h01, VEC[i][11:4]});
        2'd3: check(!rdDrive && rdData == 8'h00, int'(VEC[i][3:0]),
                    {7'd0, rdDrive, rdData}, 16'h0);
        default: ;
      endcase
    end

    // R10: strobe low, select read and RAM write have no effect
    @(negedge clk);
    accessStrobe = 1'b0; cpuWrite = 1'b0; cpuAddr = 13'h1FF9;
    #2 check(!rdDrive && rdData == 8'h00, 10, {7'd0, rdDrive, rdData}, 16'h0);
    @(negedge clk);
    cpuWrite = 1'b1; cpuAddr = 13'h1010; wrData = 8'hFF;
    @(negedge clk);
    accessStrobe = 1'b1; cpuWrite = 1'b0; cpuAddr = 13'h1110;
    #2 check(rdData == 8'h5A, 10, {8'h0, rdData}, 16'h005A);
    @(negedge clk);
    cpuAddr = 13'h1200;
    #2 check(romAddr == 14'h0200, 10, {2'b0, romAddr}, 16'h0200);

    // R2: reset mid-run returns to bank 2
    @(negedge clk);
    accessStrobe = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    accessStrobe = 1'b1; cpuAddr = 13'h1300;
    #2 check(romAddr == 14'h2300, 2, {2'b0, romAddr}, 16'h2300);
    check(rdData == romByte(14'h2300), 2, {8'h0, rdData}, {8'h0, romByte(14'h2300)});
    @(negedge clk);
    accessStrobe = 1'b0;
    finish();
  end
endmodule